// File: doc/BRIEF.md
# Two-Processor Byte Mailbox

This block passes bytes in both directions between a 16-bit host processor and an 8-bit slave processor. Each direction has a single holding latch and a flag that says whether the latch still holds an unread byte. The host can mark the byte it sends as a command by writing it through a separate register address. The receiving side can then tell commands apart from plain data. Each side can also raise an interrupt on the other side, and that interrupt stays pending until the receiving side clears it by reading its own interrupt register.

Both sides reach the block through a simple synchronous register port: chip select, a small register address, read and write strobes, and a data byte in each direction. Read data is combinational and is valid whenever the side's chip select is high. The side effects of a read happen only on the clock edge where both the chip select and the read strobe are high. The host sees its status flags on bit 7. The slave sees all of its flags together in one status byte, along with a mode strap input.

Top module: `xproc_mailbox`

## Requirements
- R1: After reset, both latches are empty and both interrupt outputs are low. Host register 5 reads 0x80 (transmit empty), host register 4 reads 0x00, and slave status bit 2 (transmit ready) is 1 while slave status bit 1 (receive ready) is 0.
- R2: A host write to register 0 loads the host-to-slave latch and clears the command tag. On the next cycle, slave status bit 1 is 1, slave status bit 0 is 0, slave register 1 returns the byte, and host register 5 reads 0x00.
- R3: A host write to register 8 loads the host-to-slave latch and sets the command tag. On the next cycle, slave status bit 0 is 1 and host register 6 reads 0x80. A later write to register 0 clears the tag again.
- R4: A slave read strobe on register 1 empties the host-to-slave latch. Slave status bit 1 then reads 0 and host register 5 reads 0x80.
- R5: A slave write to register 1 fills the slave-to-host latch, so host register 4 reads 0x80 and slave status bit 2 reads 0. Host register 0 returns the byte, and a host read strobe on register 0 empties the latch again.
- R6: A host write to register 1 drives `s_irq` high from the next cycle. A slave read strobe on register 2 clears it. While the interrupt is pending, slave register 2 reads 0x01.
- R7: A slave write to register 2 drives `h_irq` high from the next cycle. A host read strobe on register 1 clears it. While the interrupt is pending, host register 1 reads 0x80.
- R8: When a set and a clear of the same flag land in the same clock, the set wins. This applies to latch full versus consumed, and to interrupt raise versus clear. The latch then holds the newly written byte.
- R9: A strobe without its chip select has no effect. Slave status bit 3 follows the strap input. Unused register addresses, unused bits and any read without chip select return 0.
- R10: Read strobes on the status registers (host registers 4, 5 and 6, and slave register 0) change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs | input | 1 | Host chip select |
| h_addr | input | 4 | Host register address |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_irq | output | 1 | Interrupt to host |
| s_cs | input | 1 | Slave chip select |
| s_addr | input | 3 | Slave register address |
| s_rd | input | 1 | Slave read strobe |
| s_wr | input | 1 | Slave write strobe |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data |
| s_irq | output | 1 | Interrupt to slave |
| s_strap | input | 1 | Mode strap shown in slave status bit 3 |

## Verification
The bench targets the collisions:
- A host write landing in the same clock as the slave consuming the latch. A design that let the clear win would lose the new byte, and the slave would never see it.
- An interrupt raise meeting an interrupt clear in the same clock. Letting the clear win here would drop an interrupt silently.

It also checks several ways a design could leak state:
- The command tag must follow each host write. A tag left over from an earlier command would make plain data look like a command.
- Status reads must not clear flags as a side effect.
- Strobes without chip select must not write anything. A design that did so would corrupt the held byte.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    // Host register map; the spacing follows the byte lanes the host decodes.
    typedef enum logic [3:0] {
        HREG_DATA    = 4'h0,
        HREG_IRQ     = 4'h1,
        HREG_RXSTAT  = 4'h4,
        HREG_TXSTAT  = 4'h5,
        HREG_TAGSTAT = 4'h6,
        HREG_CMD     = 4'h8
    } hreg_e;

    // Slave register map.
    typedef enum logic [2:0] {
        SREG_STATUS = 3'd0,
        SREG_DATA   = 3'd1,
        SREG_IRQ    = 3'd2
    } sreg_e;

    // Slave status byte bit positions.
    localparam int unsigned SST_TAG   = 0;
    localparam int unsigned SST_RXRDY = 1;
    localparam int unsigned SST_TXRDY = 2;
    localparam int unsigned SST_STRAP = 3;

    // Index of each pending-interrupt cell.
    localparam int unsigned IRQ_TO_HOST  = 0;
    localparam int unsigned IRQ_TO_SLAVE = 1;
    localparam int unsigned IRQ_COUNT    = 2;

endpackage

// File: rtl/xmb_flag.sv
// Single sticky flag: set has priority over clear.
module xmb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic pend;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.pend = 1'b0;
        if (set_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.pend;
endmodule

// File: rtl/xmb_channel.sv
// One-byte latch with a full flag; a load in the same clock as a take wins.
module xmb_channel #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] din_i,
    input  logic          take_i,
    output logic [DW-1:0] dout_o,
    output logic          full_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (take_i) ch_d.full = 1'b0;
        if (load_i) begin
            ch_d.data = din_i;
            ch_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign dout_o = ch_q.data;
    assign full_o = ch_q.full;
endmodule

// File: rtl/xmb_host_regs.sv
// Host-side register decode: strobes to actions, state to read data.
module xmb_host_regs
    import xmb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          cs_i,
    input  logic [3:0]    addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] s2h_data_i,
    input  logic          s2h_full_i,
    input  logic          h2s_full_i,
    input  logic          h2s_tag_i,
    input  logic          irq_pend_i,
    output logic          load_o,
    output logic          tag_set_o,
    output logic          tag_clr_o,
    output logic          take_o,
    output logic          irq_clr_o,
    output logic          irq_raise_o,
    output logic [DW-1:0] rdata_o
);
    localparam int unsigned FLAG_BIT = DW - 1;

    logic rd_en, wr_en;
    assign rd_en = cs_i && rd_i;
    assign wr_en = cs_i && wr_i;

    always_comb begin
        tag_clr_o   = wr_en && (addr_i == HREG_DATA);
        tag_set_o   = wr_en && (addr_i == HREG_CMD);
        load_o      = tag_clr_o || tag_set_o;
        irq_raise_o = wr_en && (addr_i == HREG_IRQ);
        take_o      = rd_en && (addr_i == HREG_DATA);
        irq_clr_o   = rd_en && (addr_i == HREG_IRQ);
    end

    always_comb begin
        rdata_o = '0;
        if (cs_i) begin
            unique case (addr_i)
                HREG_DATA:    rdata_o = s2h_data_i;
                HREG_IRQ:     rdata_o[FLAG_BIT] = irq_pend_i;
                HREG_RXSTAT:  rdata_o[FLAG_BIT] = s2h_full_i;
                HREG_TXSTAT:  rdata_o[FLAG_BIT] = !h2s_full_i;
                HREG_TAGSTAT: rdata_o[FLAG_BIT] = h2s_tag_i;
                default:      rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/xmb_slave_regs.sv
// Slave-side register decode.
module xmb_slave_regs
    import xmb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          cs_i,
    input  logic [2:0]    addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] h2s_data_i,
    input  logic          h2s_full_i,
    input  logic          h2s_tag_i,
    input  logic          s2h_full_i,
    input  logic          irq_pend_i,
    input  logic          strap_i,
    output logic          load_o,
    output logic          take_o,
    output logic          irq_clr_o,
    output logic          irq_raise_o,
    output logic [DW-1:0] rdata_o
);
    logic rd_en, wr_en;
    assign rd_en = cs_i && rd_i;
    assign wr_en = cs_i && wr_i;

    always_comb begin
        load_o      = wr_en && (addr_i == SREG_DATA);
        take_o      = rd_en && (addr_i == SREG_DATA);
        irq_raise_o = wr_en && (addr_i == SREG_IRQ);
        irq_clr_o   = rd_en && (addr_i == SREG_IRQ);
    end

    always_comb begin
        rdata_o = '0;
        if (cs_i) begin
            unique case (addr_i)
                SREG_STATUS: begin
                    rdata_o[SST_TAG]   = h2s_tag_i;
                    rdata_o[SST_RXRDY] = h2s_full_i;
                    rdata_o[SST_TXRDY] = !s2h_full_i;
                    rdata_o[SST_STRAP] = strap_i;
                end
                SREG_DATA: rdata_o    = h2s_data_i;
                SREG_IRQ:  rdata_o[0] = irq_pend_i;
                default:   rdata_o    = '0;
            endcase
        end
    end
endmodule

// File: rtl/xproc_mailbox.sv
module xproc_mailbox
    import xmb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_cs,
    input  logic [3:0]        h_addr,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              s_cs,
    input  logic [2:0]        s_addr,
    input  logic              s_rd,
    input  logic              s_wr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_irq,
    input  logic              s_strap
);
    logic [DATA_W-1:0] h2s_data, s2h_data;
    logic              h2s_full, s2h_full, h2s_tag;
    logic              h_load, h_tag_set, h_tag_clr, h_take, h_irq_clr, h_irq_raise;
    logic              s_load, s_take, s_irq_clr, s_irq_raise;
    logic [IRQ_COUNT-1:0] irq_set, irq_clr, irq_pend;

    xmb_host_regs #(.DW(DATA_W)) u_hregs (
        .cs_i(h_cs), .addr_i(h_addr), .rd_i(h_rd), .wr_i(h_wr),
        .s2h_data_i(s2h_data), .s2h_full_i(s2h_full),
        .h2s_full_i(h2s_full), .h2s_tag_i(h2s_tag),
        .irq_pend_i(irq_pend[IRQ_TO_HOST]),
        .load_o(h_load), .tag_set_o(h_tag_set), .tag_clr_o(h_tag_clr),
        .take_o(h_take), .irq_clr_o(h_irq_clr), .irq_raise_o(h_irq_raise),
        .rdata_o(h_rdata)
    );

    xmb_slave_regs #(.DW(DATA_W)) u_sregs (
        .cs_i(s_cs), .addr_i(s_addr), .rd_i(s_rd), .wr_i(s_wr),
        .h2s_data_i(h2s_data), .h2s_full_i(h2s_full), .h2s_tag_i(h2s_tag),
        .s2h_full_i(s2h_full), .irq_pend_i(irq_pend[IRQ_TO_SLAVE]),
        .strap_i(s_strap),
        .load_o(s_load), .take_o(s_take), .irq_clr_o(s_irq_clr),
        .irq_raise_o(s_irq_raise), .rdata_o(s_rdata)
    );

    // Host-to-slave direction.
    xmb_channel #(.DW(DATA_W)) u_h2s (
        .clk(clk), .rst_n(rst_n), .load_i(h_load), .din_i(h_wdata),
        .take_i(s_take), .dout_o(h2s_data), .full_o(h2s_full)
    );

    // Slave-to-host direction.
    xmb_channel #(.DW(DATA_W)) u_s2h (
        .clk(clk), .rst_n(rst_n), .load_i(s_load), .din_i(s_wdata),
        .take_i(h_take), .dout_o(s2h_data), .full_o(s2h_full)
    );

    // Command tag travels with the host-to-slave byte.
    xmb_flag u_tag (
        .clk(clk), .rst_n(rst_n), .set_i(h_tag_set), .clr_i(h_tag_clr),
        .flag_o(h2s_tag)
    );

    always_comb begin
        irq_set[IRQ_TO_HOST]  = s_irq_raise;
        irq_clr[IRQ_TO_HOST]  = h_irq_clr;
        irq_set[IRQ_TO_SLAVE] = h_irq_raise;
        irq_clr[IRQ_TO_SLAVE] = s_irq_clr;
    end

    for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_irq
        xmb_flag u_pend (
            .clk(clk), .rst_n(rst_n), .set_i(irq_set[i]), .clr_i(irq_clr[i]),
            .flag_o(irq_pend[i])
        );
    end

    assign h_irq = irq_pend[IRQ_TO_HOST];
    assign s_irq = irq_pend[IRQ_TO_SLAVE];
endmodule

// File: rtl/xmb_mailbox_checker.sv
module xmb_mailbox_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       h_cs,
    input logic [3:0] h_addr,
    input logic       h_rd,
    input logic       h_wr,
    input logic [7:0] h_wdata,
    input logic       s_cs,
    input logic [2:0] s_addr,
    input logic       s_rd,
    input logic       s_wr,
    input logic       h_irq,
    input logic       s_irq,
    input logic       h2s_full,
    input logic       h2s_tag,
    input logic [7:0] h2s_data,
    input logic       s2h_full
);
    logic h_dwr, h_cwr, s_drd, s_dwr;
    assign h_dwr = h_cs && h_wr && (h_addr == 4'h0);
    assign h_cwr = h_cs && h_wr && (h_addr == 4'h8);
    assign s_drd = s_cs && s_rd && (s_addr == 3'd1);
    assign s_dwr = s_cs && s_wr && (s_addr == 3'd1);

    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        h_dwr |=> (h2s_full && !h2s_tag && h2s_data == $past(h_wdata)));

    p_cmd_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h_cwr |=> (h2s_full && h2s_tag));

    p_slave_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_drd && !h_dwr && !h_cwr) |=> !h2s_full);

    p_slave_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_dwr |=> s2h_full);

    p_irq_slave_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cs && h_wr && h_addr == 4'h1) |=> s_irq);

    p_irq_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cs && s_wr && s_addr == 3'd2) |=> h_irq);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_dwr || h_cwr) && s_drd) |=> h2s_full);

    p_no_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_cs && !s_cs) |=> ($stable(h2s_full) && $stable(s2h_full) &&
                              $stable(h2s_tag) && $stable(h_irq) && $stable(s_irq)));

    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cs && !h_wr && (h_addr == 4'h4 || h_addr == 4'h5 || h_addr == 4'h6) && !s_cs)
        |=> ($stable(h2s_full) && $stable(s2h_full) && $stable(h2s_tag) &&
             $stable(h_irq) && $stable(s_irq)));
endmodule

bind xproc_mailbox xmb_mailbox_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_cs(h_cs), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
    .s_cs(s_cs), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
    .h_irq(h_irq), .s_irq(s_irq),
    .h2s_full(h2s_full), .h2s_tag(h2s_tag), .h2s_data(h2s_data),
    .s2h_full(s2h_full)
);

// File: tb/xproc_mailbox_test.sv
module xproc_mailbox_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_cs, h_rd, h_wr;
    logic [3:0] h_addr;
    logic [7:0] h_wdata;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       s_cs, s_rd, s_wr;
    logic [2:0] s_addr;
    logic [7:0] s_wdata;
    logic [7:0] s_rdata;
    logic       s_irq;
    logic       s_strap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xproc_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .h_cs(h_cs), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
        .s_cs(s_cs), .s_addr(s_addr), .s_rd(s_rd), .s_wr(s_wr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_irq(s_irq),
        .s_strap(s_strap)
    );

    // Behavioural reference: one queue per direction (at most one entry).
    byte unsigned q_h2s[$];
    byte unsigned q_s2h[$];
    int m_h2s_last = 0, m_s2h_last = 0;
    int m_tag = 0, m_hirq = 0, m_sirq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_h2s.delete(); q_s2h.delete();
            m_h2s_last = 0; m_s2h_last = 0;
            m_tag = 0; m_hirq = 0; m_sirq = 0;
        end else begin
            // Consumption first, then production, so a same-clock write survives.
            if (s_cs && s_rd && s_addr == 1 && q_h2s.size() > 0) void'(q_h2s.pop_front());
            if (h_cs && h_rd && h_addr == 0 && q_s2h.size() > 0) void'(q_s2h.pop_front());
            if (h_cs && h_rd && h_addr == 1) m_hirq = 0;
            if (s_cs && s_rd && s_addr == 2) m_sirq = 0;
            if (h_cs && h_wr && (h_addr == 0 || h_addr == 8)) begin
                q_h2s.delete(); q_h2s.push_back(h_wdata);
                m_h2s_last = h_wdata; m_tag = (h_addr == 8);
            end
            if (s_cs && s_wr && s_addr == 1) begin
                q_s2h.delete(); q_s2h.push_back(s_wdata);
                m_s2h_last = s_wdata;
            end
            if (h_cs && h_wr && h_addr == 1) m_sirq = 1;
            if (s_cs && s_wr && s_addr == 2) m_hirq = 1;
        end
    end

    function automatic int exp_h_rdata();
        if (!h_cs) return 0;
        case (h_addr)
            4'h0: return m_s2h_last;
            4'h1: return m_hirq ? 8'h80 : 0;
            4'h4: return (q_s2h.size() > 0) ? 8'h80 : 0;
            4'h5: return (q_h2s.size() == 0) ? 8'h80 : 0;
            4'h6: return m_tag ? 8'h80 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_s_rdata();
        if (!s_cs) return 0;
        case (s_addr)
            3'd0: return m_tag + ((q_h2s.size() > 0) ? 2 : 0)
                         + ((q_s2h.size() == 0) ? 4 : 0) + (s_strap ? 8 : 0);
            3'd1: return m_h2s_last;
            3'd2: return m_sirq;
            default: return 0;
        endcase
    endfunction

    function automatic string hreq(input logic [3:0] a);
        case (a)
            4'h0: return "R5";
            4'h1: return "R7";
            4'h4: return "R5";
            4'h5: return "R4";
            4'h6: return "R3";
            default: return "R9";
        endcase
    endfunction

    function automatic string sreq(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R2";
            3'd2: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, sampled between edges.
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk({hreq(h_addr), " host read"}, h_rdata, exp_h_rdata());
            chk({sreq(s_addr), " slave read"}, s_rdata, exp_s_rdata());
            chk("R7 h_irq", h_irq, m_hirq);
            chk("R6 s_irq", s_irq, m_sirq);
        end
    end

    task automatic op(input logic hc, input logic [3:0] ha, input logic hr, input logic hw,
                      input logic [7:0] hd, input logic sc, input logic [2:0] sa,
                      input logic sr, input logic sw, input logic [7:0] sd);
        @(negedge clk);
        h_cs = hc; h_addr = ha; h_rd = hr; h_wr = hw; h_wdata = hd;
        s_cs = sc; s_addr = sa; s_rd = sr; s_wr = sw; s_wdata = sd;
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic hpeek(input logic [3:0] a, input int exp, input string req);
        op(1, a, 0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #3;
        chk(req, h_rdata, exp);
    endtask

    task automatic speek(input logic [2:0] a, input int exp, input string req);
        op(0, 0, 0, 0, 0, 1, a, 0, 0, 0);
        @(posedge clk); #3;
        chk(req, s_rdata, exp);
    endtask

    task automatic irqchk(input int eh, input int es, input string req);
        idle();
        @(posedge clk); #3;
        chk({req, " h_irq"}, h_irq, eh);
        chk({req, " s_irq"}, s_irq, es);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; s_strap = 1;
        h_cs = 0; h_addr = 0; h_rd = 0; h_wr = 0; h_wdata = 0;
        s_cs = 0; s_addr = 0; s_rd = 0; s_wr = 0; s_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        irqchk(0, 0, "R1");
        hpeek(4'h5, 8'h80, "R1 host tx empty");
        hpeek(4'h4, 8'h00, "R1 host rx empty");
        speek(3'd0, 8'h0C, "R1 slave status");

        // R2 plain data write
        op(1, 4'h0, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
        speek(3'd0, 8'h0E, "R2 slave status");
        speek(3'd1, 8'hA5, "R2 slave data");
        hpeek(4'h6, 8'h00, "R2 tag clear");
        hpeek(4'h5, 8'h00, "R2 host tx busy");

        // R4 slave consumes
        op(0, 0, 0, 0, 0, 1, 3'd1, 1, 0, 0);
        speek(3'd0, 8'h0C, "R4 slave status");
        hpeek(4'h5, 8'h80, "R4 host tx empty");

        // R3 command write, then plain write clears the tag
        op(1, 4'h8, 0, 1, 8'h3C, 0, 0, 0, 0, 0);
        speek(3'd0, 8'h0F, "R3 slave status");
        hpeek(4'h6, 8'h80, "R3 tag set");
        op(0, 0, 0, 0, 0, 1, 3'd1, 1, 0, 0);
        op(1, 4'h0, 0, 1, 8'h11, 0, 0, 0, 0, 0);
        hpeek(4'h6, 8'h00, "R3 tag cleared");

        // R5 slave to host
        op(0, 0, 0, 0, 0, 1, 3'd1, 0, 1, 8'h5A);
        hpeek(4'h4, 8'h80, "R5 host rx full");
        speek(3'd0, 8'h0A, "R5 slave status");
        hpeek(4'h0, 8'h5A, "R5 host data");
        op(1, 4'h0, 1, 0, 0, 0, 0, 0, 0, 0);
        hpeek(4'h4, 8'h00, "R5 host rx empty");
        speek(3'd0, 8'h0E, "R5 slave tx ready");

        // R6 host interrupts slave
        op(1, 4'h1, 0, 1, 0, 0, 0, 0, 0, 0);
        irqchk(0, 1, "R6 raise");
        speek(3'd2, 8'h01, "R6 slave irq reg");
        op(0, 0, 0, 0, 0, 1, 3'd2, 1, 0, 0);
        irqchk(0, 0, "R6 clear");

        // R7 slave interrupts host
        op(0, 0, 0, 0, 0, 1, 3'd2, 0, 1, 0);
        irqchk(1, 0, "R7 raise");
        hpeek(4'h1, 8'h80, "R7 host irq reg");
        op(1, 4'h1, 1, 0, 0, 0, 0, 0, 0, 0);
        irqchk(0, 0, "R7 clear");

        // R8 same-clock set and clear
        op(1, 4'h0, 0, 1, 8'h77, 1, 3'd1, 1, 0, 0);
        speek(3'd1, 8'h77, "R8 new byte kept");
        speek(3'd0, 8'h0E, "R8 rx ready kept");
        op(1, 4'h1, 0, 1, 0, 1, 3'd2, 1, 0, 0);
        irqchk(0, 1, "R8 slave irq kept");
        op(1, 4'h1, 1, 0, 0, 1, 3'd2, 0, 1, 0);
        irqchk(1, 1, "R8 host irq kept");
        op(1, 4'h0, 1, 0, 0, 1, 3'd1, 0, 1, 8'hC3);
        hpeek(4'h4, 8'h80, "R8 s2h kept full");
        op(1, 4'h0, 1, 0, 0, 0, 0, 0, 0, 0);
        op(1, 4'h1, 1, 0, 0, 1, 3'd2, 1, 0, 0);
        irqchk(0, 0, "R8 cleanup");

        // R9 strobes without select, strap, unused addresses
        op(0, 4'h0, 0, 1, 8'hFF, 0, 3'd1, 0, 1, 8'hEE);
        op(0, 4'h1, 0, 1, 8'h00, 0, 3'd2, 0, 1, 8'h00);
        irqchk(0, 0, "R9 no select irq");
        speek(3'd1, 8'h77, "R9 latch untouched");
        hpeek(4'h4, 8'h00, "R9 s2h untouched");
        s_strap = 0;
        speek(3'd0, 8'h06, "R9 strap low");
        hpeek(4'h2, 8'h00, "R9 unused host reg");
        speek(3'd5, 8'h00, "R9 unused slave reg");
        idle(); @(posedge clk); #3;
        chk("R9 no select read", h_rdata, 0);

        // R10 status reads have no side effects
        op(1, 4'h4, 1, 0, 0, 0, 0, 0, 0, 0);
        op(1, 4'h5, 1, 0, 0, 0, 0, 0, 0, 0);
        op(1, 4'h6, 1, 0, 0, 0, 0, 0, 0, 0);
        speek(3'd0, 8'h06, "R10 slave status after host status reads");
        op(0, 0, 0, 0, 0, 1, 3'd0, 1, 0, 0);
        hpeek(4'h5, 8'h00, "R10 host tx after slave status read");

        idle();
        repeat (2) @(posedge clk);
        #3;
        done = 1;
        summary();
        $finish;
    end
endmodule